// File: doc/BRIEF.md
# Clock Generator Configuration Register Bank

This block keeps the settings that steer a line-locked pixel clock generator. A host writes and reads them one byte at a time through a plain port: an 8-bit register index, a write strobe with a data byte, and a read data byte that follows the index in the same cycle. The block drives the live settings out in parallel to the clock generator. These settings are a 12-bit feedback divide ratio, a two-bit operating range, a three-bit loop current code and a five-bit sampling phase. A fixed revision byte can be read back.

The divide ratio is held twice. A pending copy is loaded in two parts: the upper eight bits at index 0x01 and the lower four bits in the top nibble of index 0x02. The live copy is loaded from the pending copy only when index 0x02 is written, so the generator never sees a ratio with one half old and one half new. The generator needs a count one greater than the programmed ratio, so that count is also driven out. The usable programmed range is 2 to 4095.

Top module: `clkcfg_regs`

## Requirements
- R1: Reading index 0x00 returns the revision value 0x01, and a write to index 0x00 changes no output and no read value.
- R2: After reset the live ratio is 1693, the live count is 1694, the range field is 2'b00, the current code is 3'b001 and the phase is 16. Index 0x01 reads 0x69 and index 0x02 reads 0xD0.
- R3: A write to index 0x01 loads only the pending upper byte. The live ratio and live count do not change.
- R4: A write to index 0x02 sets the live ratio, from the next clock edge, to {pending upper byte, write data bits 7:4}. The live ratio changes at no other time.
- R5: The live count output always equals the live ratio plus one, as a 13-bit value.
- R6: Index 0x01 reads back the pending upper byte. Index 0x02 reads back the pending lower nibble in bits 7:4. Neither read returns the live ratio.
- R7: A write to index 0x03 sets the range field from data bits 7:6 and the current code from bits 5:3. Index 0x03 reads back {range, current, 3'b000}.
- R8: A write to index 0x04 sets the phase from data bits 7:3. Index 0x04 reads back {phase, 3'b000}.
- R9: Bits 3:0 of index 0x02 and bits 2:0 of indices 0x03 and 0x04 read as zero, whatever was written to them.
- R10: Writes to indices 0x05 to 0xFF change no output and no read value, and reads of those indices return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 8 | Register index for the read and the write |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data for the current index, combinational |
| div_ratio_o | output | 12 | Live programmed divide ratio |
| div_count_o | output | 13 | Live ratio plus one |
| vco_range_o | output | 2 | Live generator range select |
| pump_cur_o | output | 3 | Live loop current code |
| phase_o | output | 5 | Live sampling phase step |

## Verification
Directed sequences write the upper byte alone and then read the live ratio. This separates a correct staged ratio from one that passes each half straight through. They also write the upper byte twice before a single lower write, which shows that only the latest pending byte is committed. Random writes are spread over the mapped indices, index 0x00 and unmapped indices, with random data. After each write every output and every mapped read is compared with a bench model, which exposes wrong bit positions, unmasked unused bits and writes that leak through the decode. Boundary ratios 2 and 4095 check the width of the plus-one count.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned HI_W    = 8;
  localparam int unsigned LO_W    = 4;
  localparam int unsigned RATIO_W = HI_W + LO_W;
  localparam int unsigned RNG_W   = 2;
  localparam int unsigned CUR_W   = 3;
  localparam int unsigned PH_W    = 5;

  localparam logic [IDX_W-1:0] IDX_REV    = 8'h00;
  localparam logic [IDX_W-1:0] IDX_DIVHI  = 8'h01;
  localparam logic [IDX_W-1:0] IDX_DIVLO  = 8'h02;
  localparam logic [IDX_W-1:0] IDX_CLKGEN = 8'h03;
  localparam logic [IDX_W-1:0] IDX_PHASE  = 8'h04;

  localparam logic [BYTE_W-1:0]  REV_VALUE = 8'h01;
  localparam logic [RATIO_W-1:0] RATIO_RST = 12'd1693;
  localparam logic [RNG_W-1:0]   RNG_RST   = 2'b00;
  localparam logic [CUR_W-1:0]   CUR_RST   = 3'b001;
  localparam logic [PH_W-1:0]    PH_RST    = 5'd16;

  typedef struct packed {
    logic div_hi;
    logic div_lo;
    logic clkgen;
    logic phase;
  } wr_sel_t;
endpackage

// File: rtl/clkcfg_rst_sync.sv
module clkcfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/clkcfg_wr_dec.sv
module clkcfg_wr_dec
  import clkcfg_pkg::*;
(
  input  logic             wr_en,
  input  logic [IDX_W-1:0] addr,
  output wr_sel_t          sel
);
  always_comb begin
    sel = '0;
    if (wr_en) begin
      unique case (addr)
        IDX_DIVHI:  sel.div_hi = 1'b1;
        IDX_DIVLO:  sel.div_lo = 1'b1;
        IDX_CLKGEN: sel.clkgen = 1'b1;
        IDX_PHASE:  sel.phase  = 1'b1;
        default:    sel = '0;
      endcase
    end
  end
endmodule

// File: rtl/clkcfg_field_reg.sv
module clkcfg_field_reg #(
  parameter int unsigned    W   = 4,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_next;
  end
endmodule

// File: rtl/clkcfg_div_stage.sv
module clkcfg_div_stage #(
  parameter int unsigned HI_W = 8,
  parameter int unsigned LO_W = 4,
  parameter logic [HI_W+LO_W-1:0] RST = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hi_we,
  input  logic                 lo_we,
  input  logic [HI_W-1:0]      hi_d,
  input  logic [LO_W-1:0]      lo_d,
  output logic [HI_W-1:0]      pend_hi,
  output logic [LO_W-1:0]      pend_lo,
  output logic [HI_W+LO_W-1:0] active
);
  localparam int unsigned TOT_W = HI_W + LO_W;

  logic [HI_W-1:0]  pend_hi_next;
  logic [LO_W-1:0]  pend_lo_next;
  logic [TOT_W-1:0] active_next;

  always_comb begin
    pend_hi_next = hi_we ? hi_d : pend_hi;
    pend_lo_next = lo_we ? lo_d : pend_lo;
    // the low write is the commit point: both halves move together
    active_next  = lo_we ? {pend_hi, lo_d} : active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_hi <= RST[TOT_W-1:LO_W];
      pend_lo <= RST[LO_W-1:0];
      active  <= RST;
    end else begin
      pend_hi <= pend_hi_next;
      pend_lo <= pend_lo_next;
      active  <= active_next;
    end
  end
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
  import clkcfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   addr,
  input  logic [BYTE_W-1:0]  wr_data,
  output logic [BYTE_W-1:0]  rd_data,
  output logic [RATIO_W-1:0] div_ratio_o,
  output logic [RATIO_W:0]   div_count_o,
  output logic [RNG_W-1:0]   vco_range_o,
  output logic [CUR_W-1:0]   pump_cur_o,
  output logic [PH_W-1:0]    phase_o
);
  localparam int unsigned CG_W    = RNG_W + CUR_W;
  localparam int unsigned CG_PAD  = BYTE_W - CG_W;
  localparam int unsigned PH_PAD  = BYTE_W - PH_W;
  localparam int unsigned LO_PAD  = BYTE_W - LO_W;

  logic                rst_sync_n;
  wr_sel_t             sel;
  logic [HI_W-1:0]     pend_hi;
  logic [LO_W-1:0]     pend_lo;
  logic [CG_W-1:0]     clkgen_q;

  clkcfg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  clkcfg_wr_dec u_dec (.wr_en(wr_en), .addr(addr), .sel(sel));

  clkcfg_div_stage #(.HI_W(HI_W), .LO_W(LO_W), .RST(RATIO_RST)) u_div (
    .clk(clk), .rst_n(rst_sync_n),
    .hi_we(sel.div_hi), .lo_we(sel.div_lo),
    .hi_d(wr_data), .lo_d(wr_data[BYTE_W-1 -: LO_W]),
    .pend_hi(pend_hi), .pend_lo(pend_lo), .active(div_ratio_o)
  );

  clkcfg_field_reg #(.W(CG_W), .RST({RNG_RST, CUR_RST})) u_clkgen (
    .clk(clk), .rst_n(rst_sync_n), .en(sel.clkgen),
    .d(wr_data[BYTE_W-1 -: CG_W]), .q(clkgen_q)
  );

  clkcfg_field_reg #(.W(PH_W), .RST(PH_RST)) u_phase (
    .clk(clk), .rst_n(rst_sync_n), .en(sel.phase),
    .d(wr_data[BYTE_W-1 -: PH_W]), .q(phase_o)
  );

  assign vco_range_o = clkgen_q[CG_W-1 -: RNG_W];
  assign pump_cur_o  = clkgen_q[CUR_W-1:0];
  assign div_count_o = {1'b0, div_ratio_o} + {{RATIO_W{1'b0}}, 1'b1};

  always_comb begin
    unique case (addr)
      IDX_REV:    rd_data = REV_VALUE;
      IDX_DIVHI:  rd_data = pend_hi;
      IDX_DIVLO:  rd_data = {pend_lo, {LO_PAD{1'b0}}};
      IDX_CLKGEN: rd_data = {clkgen_q, {CG_PAD{1'b0}}};
      IDX_PHASE:  rd_data = {phase_o, {PH_PAD{1'b0}}};
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/clkcfg_regs_chk.sv
module clkcfg_regs_chk
  import clkcfg_pkg::*;
(
  input logic               clk,
  input logic               rst_ok,
  input logic               wr_en,
  input logic [IDX_W-1:0]   addr,
  input logic [BYTE_W-1:0]  wr_data,
  input logic [BYTE_W-1:0]  rd_data,
  input logic [RATIO_W-1:0] div_ratio_o,
  input logic [RATIO_W:0]   div_count_o,
  input logic [RNG_W-1:0]   vco_range_o,
  input logic [PH_W-1:0]    phase_o
);
  // R1
  rev_read_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (addr == IDX_REV) |-> (rd_data == 8'h01));

  // R3
  hi_only_stable_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && addr == IDX_DIVHI) |=> $stable(div_ratio_o));

  // R4
  lo_commit_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && addr == IDX_DIVLO) |=> (div_ratio_o[3:0] == $past(wr_data[7:4])));

  // R4
  no_commit_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(wr_en && addr == IDX_DIVLO) |=> $stable(div_ratio_o));

  // R5
  count_follow_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $stable(div_ratio_o) |-> $stable(div_count_o));

  // R7
  range_load_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && addr == IDX_CLKGEN) |=> (vco_range_o == $past(wr_data[7:6])));

  // R8
  phase_load_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && addr == IDX_PHASE) |=> (phase_o == $past(wr_data[7:3])));

  // R9
  lo_pad_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (addr == IDX_DIVLO) |-> (rd_data[3:0] == 4'h0));

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (addr > IDX_PHASE) |-> (rd_data == 8'h00));
endmodule

bind clkcfg_regs clkcfg_regs_chk u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .div_ratio_o(div_ratio_o),
  .div_count_o(div_count_o), .vco_range_o(vco_range_o), .phase_o(phase_o)
);

// File: tb/clkcfg_regs_tb.sv
module clkcfg_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic [11:0] div_ratio_o;
  logic [12:0] div_count_o;
  logic [1:0]  vco_range_o;
  logic [2:0]  pump_cur_o;
  logic [4:0]  phase_o;

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          done = 1'b0;

  logic [7:0]  m_hi;
  logic [3:0]  m_lo;
  logic [11:0] m_ratio;
  logic [1:0]  m_rng;
  logic [2:0]  m_cur;
  logic [4:0]  m_ph;

  always #5 clk = ~clk;

  clkcfg_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .div_ratio_o(div_ratio_o), .div_count_o(div_count_o),
    .vco_range_o(vco_range_o), .pump_cur_o(pump_cur_o), .phase_o(phase_o)
  );

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00:   return 8'h01;
      8'h01:   return m_hi;
      8'h02:   return {m_lo, 4'h0};
      8'h03:   return {m_rng, m_cur, 3'b000};
      8'h04:   return {m_ph, 3'b000};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_hi = 8'h69; m_lo = 4'hD; m_ratio = 12'd1693;
    m_rng = 2'b00; m_cur = 3'b001; m_ph = 5'd16;
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h01: m_hi = d;
      8'h02: begin m_lo = d[7:4]; m_ratio = {m_hi, d[7:4]}; end
      8'h03: begin m_rng = d[7:6]; m_cur = d[5:3]; end
      8'h04: m_ph = d[7:3];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic read_chk(input string req, input logic [7:0] a);
    @(negedge clk);
    addr = a;
    #1;
    check(req, {24'h0, rd_data}, {24'h0, exp_rd(a)});
  endtask

  task automatic out_chk(input string req);
    @(negedge clk);
    #1;
    check({req, " ratio"}, {20'h0, div_ratio_o}, {20'h0, m_ratio});
    check("R5 count", {19'h0, div_count_o}, {19'h0, 13'(m_ratio) + 13'd1});
    check({req, " range"}, {30'h0, vco_range_o}, {30'h0, m_rng});
    check({req, " current"}, {29'h0, pump_cur_o}, {29'h0, m_cur});
    check({req, " phase"}, {27'h0, phase_o}, {27'h0, m_ph});
  endtask

  task automatic all_reads(input string req);
    for (int a = 0; a < 6; a++) read_chk(req, 8'(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    out_chk("R2");
    all_reads("R2");
    read_chk("R1", 8'h00);

    // R3 upper byte alone leaves live ratio
    wr(8'h01, 8'h12);
    out_chk("R3");
    read_chk("R6", 8'h01);
    read_chk("R6", 8'h02);
    // R3 second upper write, only latest committed
    wr(8'h01, 8'hA5);
    out_chk("R3");
    wr(8'h02, 8'h3F);
    out_chk("R4");
    check("R4 commit", {20'h0, div_ratio_o}, 32'hA53);
    read_chk("R9", 8'h02);

    // R5 boundaries
    wr(8'h01, 8'h00); wr(8'h02, 8'h20);
    out_chk("R5");
    check("R5 min", {19'h0, div_count_o}, 32'd3);
    wr(8'h01, 8'hFF); wr(8'h02, 8'hF7);
    out_chk("R5");
    check("R5 max", {19'h0, div_count_o}, 32'd4096);

    // R7 R8 R9 fields and padding
    wr(8'h03, 8'hFF);
    out_chk("R7");
    read_chk("R9", 8'h03);
    wr(8'h04, 8'h8F);
    out_chk("R8");
    read_chk("R9", 8'h04);

    // R1 R10 ignored writes
    wr(8'h00, 8'hEE);
    out_chk("R1");
    all_reads("R1");
    wr(8'hFF, 8'h5A);
    out_chk("R10");
    all_reads("R10");
    read_chk("R10", 8'h80);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [7:0] d;
      d = 8'($urandom);
      a = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 6);
      wr(a, d);
      out_chk("R4");
      all_reads("R6");
      read_chk("R10", a);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule